// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave end of a two-wire serial bus in front of a 256-byte memory. The clock and data lines are sampled on the system clock. The block finds START and STOP conditions and decodes a device-address byte whose middle bits must equal three strap inputs. It then receives a word address and data bytes, or returns memory bytes to the master. It acknowledges by pulling the data line low through an open-drain enable. That enable also carries the read data.

Write data goes into a one-page staging buffer. The memory is not touched until a STOP closes the write. STOP then starts a timed write cycle. In the first cycles of that window, each staged byte is offered to an external protection check and stored only if the check allows it. For the rest of the window the device stays busy and ignores its own address. Reads can be random, sequential or from the current address.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A START (data falling while clock high) from any state restarts device-address reception. A STOP (data rising while clock high) returns the block to idle.
- R2: The device-address byte is sent MSB first and decodes as follows. Bits 7..4 must equal DEV_ID (default 4'b1010). Bits 3..1 must equal strap_i. Bit 0 is the direction, with 1 meaning read. On a match the block pulls SDA low for the ninth clock. On a mismatch it stays silent until the next START.
- R3: sda_oe_o changes only while SCL is low. Incoming bits are taken on SCL rising edges.
- R4: A byte write is a word-address byte followed by one data byte. The byte appears at that address once STOP and the write cycle are complete.
- R5: In a multi-byte write, the low 4 address bits advance and wrap inside the 16-byte page. The upper 4 bits stay fixed, and the last byte written to a location wins.
- R6: A write cycle of WR_CYCLES clocks starts only at a STOP that ends a write holding at least one data byte. While it runs, the device address is not acknowledged.
- R7: Each staged byte is presented on chk_addr_o during its commit cycle. If chk_deny_i is high in that cycle, the byte is dropped and the location keeps its old value.
- R8: A random read is a write-direction address byte, a word address, a repeated START and a read-direction address byte. It returns the byte at that word address.
- R9: Each byte sent advances the read pointer across the full 8-bit range, rolling over from 0xFF to 0x00. A read with no word address continues from the pointer.
- R10: A master NACK after a read byte makes the block release SDA and ignore the bus until the next START or STOP.
- R11: After reset, sda_oe_o is low, no write cycle is pending and the device acknowledges its address at once.
- R12: A write that a repeated START interrupts before any STOP is discarded and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| strap_i | input | 3 | Device-address strap bits |
| chk_deny_i | input | 1 | Protection verdict for the address on chk_addr_o; high blocks the commit |
| chk_addr_o | output | 8 | Memory address of the byte being committed |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
The assertions check three things on every cycle:
- the open-drain enable holds steady while the sampled clock is high and stays released in idle;
- the page bits of the pointer stay put across a data byte;
- a device-address acknowledge never happens during a write cycle, and a write cycle only begins on a STOP.

Other behaviour shows only in the bench scenarios. These cover page wrap with overwrite, denied commits leaving old data, pointer rollover across 0xFF, the discard of a write cut short by a repeated START, and the busy window measured from outside through NACKed address bytes.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [3:0] {
    S_IDLE,  // ignore bus until START
    S_DEV,   // shifting device-address byte
    S_DACK,  // acknowledging device address
    S_WADR,  // shifting word address
    S_AACK,  // acknowledging word address
    S_WDAT,  // shifting write data
    S_WACK,  // acknowledging write data
    S_RDAT,  // sending read data
    S_RACK   // sampling master acknowledge
  } bus_st_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N:0] scl_sh, sda_sh;
  logic scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_N-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_N-1:0], sda_i};
    end
  end

  assign scl_o   = scl_sh[SYNC_N-1];
  assign sda_o   = sda_sh[SYNC_N-1];
  assign scl_old = scl_sh[SYNC_N];
  assign sda_old = sda_sh[SYNC_N];

  assign scl_rise_o = scl_o & ~scl_old;
  assign scl_fall_o = ~scl_o & scl_old;
  assign start_o    = scl_o & scl_old & sda_old & ~sda_o;
  assign stop_o     = scl_o & scl_old & ~sda_old & sda_o;
endmodule

// File: rtl/twi_busctl.sv
module twi_busctl
  import twi_eeprom_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          PAGE_W = 4,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic                     scl_rise_i,
  input  logic                     scl_fall_i,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic [2:0]               strap_i,
  input  logic                     busy_i,
  input  logic [7:0]               rd_data_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic                     wb_we_o,
  output logic [PAGE_W-1:0]        wb_idx_o,
  output logic [ADDR_W-PAGE_W-1:0] wb_page_o,
  output logic [7:0]               wb_data_o,
  output logic                     sda_oe_o
);
  bus_st_e           st, st_n;
  logic [3:0]        bitcnt, cnt_n;
  logic [7:0]        shreg, sh_n, tx, tx_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic              oe_n, dev_hit;

  assign dev_hit   = (shreg[7:4] == DEV_ID) && (shreg[3:1] == strap_i) && !busy_i;
  assign rd_addr_o = ptr;
  assign wb_idx_o  = ptr[PAGE_W-1:0];
  assign wb_page_o = ptr[ADDR_W-1:PAGE_W];
  assign wb_data_o = shreg;

  always_comb begin
    st_n = st; cnt_n = bitcnt; sh_n = shreg; tx_n = tx; ptr_n = ptr;
    oe_n = sda_oe_o; wb_we_o = 1'b0;
    if (start_i) begin
      st_n = S_DEV; cnt_n = '0; oe_n = 1'b0;
    end else if (stop_i) begin
      st_n = S_IDLE; oe_n = 1'b0;
    end else begin
      if (scl_rise_i) begin
        if (st inside {S_DEV, S_WADR, S_WDAT, S_RACK}) sh_n = {shreg[6:0], sda_i};
        if (st inside {S_DEV, S_WADR, S_WDAT, S_RDAT}) cnt_n = bitcnt + 4'd1;
      end
      if (scl_fall_i) begin
        case (st)
          S_DEV: if (bitcnt == 4'd8) begin
            cnt_n = '0;
            if (dev_hit) begin st_n = S_DACK; oe_n = 1'b1; end
            else st_n = S_IDLE;
          end
          S_WADR: if (bitcnt == 4'd8) begin
            cnt_n = '0; ptr_n = shreg; st_n = S_AACK; oe_n = 1'b1;
          end
          S_WDAT: if (bitcnt == 4'd8) begin
            cnt_n = '0; wb_we_o = 1'b1; st_n = S_WACK; oe_n = 1'b1;
            ptr_n = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
          end
          S_AACK, S_WACK: begin
            oe_n = 1'b0; st_n = S_WDAT;
          end
          S_RDAT: if (bitcnt == 4'd8) begin
            cnt_n = '0; oe_n = 1'b0; st_n = S_RACK;
          end else begin
            oe_n = ~tx[7]; tx_n = {tx[6:0], 1'b0};
          end
          S_DACK, S_RACK: begin
            // S_DACK: shreg[0] is the direction bit; S_RACK: master ack bit
            if ((st == S_DACK) ? shreg[0] : !shreg[0]) begin
              tx_n = {rd_data_i[6:0], 1'b0}; oe_n = ~rd_data_i[7];
              ptr_n = ptr + ADDR_W'(1); st_n = S_RDAT;
            end else begin
              oe_n = 1'b0; st_n = (st == S_DACK) ? S_WADR : S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0; sda_oe_o <= 1'b0;
    end else begin
      st <= st_n; bitcnt <= cnt_n; shreg <= sh_n; tx <= tx_n; ptr <= ptr_n; sda_oe_o <= oe_n;
    end
  end

  // R3: the driven level never moves while the sampled clock is high
  a_r3_oe_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && !start_i && !stop_i) |=> $stable(sda_oe_o));
  // R10: idle (after NACK, mismatch or STOP) never pulls the line
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe_o);
  // R6: no device-address acknowledge during a write cycle
  a_r6_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DACK && $past(st) == S_DEV) |-> !$past(busy_i));
  // R5: page bits of the pointer survive a received data byte
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WDAT && scl_fall_i && bitcnt == 4'd8 && !start_i && !stop_i)
      |=> $stable(ptr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/twi_pagebuf.sv
module twi_pagebuf #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 625000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [PAGE_W-1:0]        idx_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [7:0]               data_i,
  input  logic                     clr_i,
  input  logic                     stop_i,
  input  logic                     deny_i,
  output logic                     busy_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [7:0]               mem_wdata_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(WR_CYCLES) + 1;

  logic [7:0]              dat [PAGE_N];
  logic                    vld [PAGE_N];
  logic [ADDR_W-PAGE_W-1:0] pg;
  logic [CNT_W-1:0]        tmr, tmr_n;
  logic                    busy_n, any_vld, go, done, take, drop;
  logic [PAGE_W-1:0]       cidx;

  always_comb begin
    any_vld = 1'b0;
    for (int k = 0; k < PAGE_N; k++) any_vld = any_vld | vld[k];
  end

  assign take = we_i && !busy_o;
  assign go   = stop_i && !busy_o && any_vld;
  assign done = busy_o && (tmr == CNT_W'(WR_CYCLES - 1));
  assign drop = done || (clr_i && !busy_o);
  assign cidx = tmr[PAGE_W-1:0];

  for (genvar g = 0; g < PAGE_N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                vld[g] <= 1'b0;
      else if (drop)                             vld[g] <= 1'b0;
      else if (take && idx_i == PAGE_W'(g))      vld[g] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (take && idx_i == PAGE_W'(g)) dat[g] <= data_i;
    end
  end

  always_comb begin
    busy_n = busy_o; tmr_n = tmr;
    if (go) begin busy_n = 1'b1; tmr_n = '0; end
    else if (done) busy_n = 1'b0;
    else if (busy_o) tmr_n = tmr + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0; tmr <= '0; pg <= '0;
    end else begin
      busy_o <= busy_n; tmr <= tmr_n;
      if (take) pg <= page_i;
    end
  end

  assign mem_addr_o  = {pg, cidx};
  assign mem_wdata_o = dat[cidx];
  assign mem_we_o    = busy_o && (tmr < CNT_W'(PAGE_N)) && vld[cidx] && !deny_i;

  // R6: a write cycle opens only on a STOP
  a_r6_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter logic [3:0] DEV_ID    = 4'b1010,
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_W    = 4,
  parameter int         SYNC_N    = 2,
  parameter int         WR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              chk_deny_i,
  output logic [ADDR_W-1:0] chk_addr_o,
  output logic              sda_oe_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - PAGE_W;

  logic [1:0]        rs;
  logic              rst_q_n;
  logic              scl_s, sda_s, rise, fall, start, stop, busy;
  logic [ADDR_W-1:0] rd_addr, mem_addr;
  logic [7:0]        rd_data, wb_data, mem_wdata;
  logic              wb_we, mem_we;
  logic [PAGE_W-1:0] wb_idx;
  logic [HI_W-1:0]   wb_page;
  logic [7:0]        mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= '0;
    else        rs <= {rs[0], 1'b1};
  end
  assign rst_q_n = rs[1];

  twi_line_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop));

  twi_busctl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_ID(DEV_ID)) u_bus (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(rise), .scl_fall_i(fall), .start_i(start), .stop_i(stop),
    .strap_i(strap_i), .busy_i(busy), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wb_we_o(wb_we), .wb_idx_o(wb_idx), .wb_page_o(wb_page), .wb_data_o(wb_data),
    .sda_oe_o(sda_oe_o));

  twi_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_buf (
    .clk(clk), .rst_n(rst_q_n), .we_i(wb_we), .idx_i(wb_idx), .page_i(wb_page),
    .data_i(wb_data), .clr_i(start), .stop_i(stop), .deny_i(chk_deny_i),
    .busy_o(busy), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end
  assign rd_data    = mem[rd_addr];
  assign chk_addr_o = mem_addr;
endmodule

// File: tb/twi_eeprom_slave_tb.sv
module twi_eeprom_slave_tb_top;
  localparam int Q   = 10;
  localparam int WRC = 2000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, lock_lo = 1'b0;
  logic sda_oe, deny;
  logic [7:0] chk_addr;
  wire  sda_w = sda_m & ~sda_oe;

  int n_cmp = 0, n_bad = 0, r3_viol = 0;
  logic [7:0] mem_m [256];
  int ptr_m = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign deny = lock_lo && (chk_addr < 8'h80);

  twi_eeprom_slave #(.WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .strap_i(STRAP),
    .chk_deny_i(deny), .chk_addr_o(chk_addr), .sda_oe_o(sda_oe));

  // R3 monitor: the slave's drive must not move while the real clock is high
  logic p_scl = 1'b1, p_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && p_scl && (sda_oe !== p_oe)) r3_viol++;
    p_scl <= scl_m; p_oe <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(2);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(2);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q/2);
    ack = (sda_w == 1'b0);
    wq(Q/2); scl_m = 1'b0; wq(2);
    chk(req, int'(ack), int'(exp_ack));
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1; b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_m = 1'b1; wq(Q/2); b = {b[6:0], sda_w}; wq(Q/2); scl_m = 1'b0; wq(2);
    end
    sda_m = mack ? 1'b0 : 1'b1; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(2); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic wr_seq(input logic [7:0] addr, input logic [7:0] d[$], input string req);
    logic [7:0] pv [16];
    bit pm [16];
    for (int k = 0; k < 16; k++) pm[k] = 0;
    bus_start;
    tx_byte(dev(1'b0), 1'b1, req);
    tx_byte(addr, 1'b1, req);
    foreach (d[i]) begin
      tx_byte(d[i], 1'b1, req);
      pv[(addr[3:0] + i) % 16] = d[i];
      pm[(addr[3:0] + i) % 16] = 1;
    end
    bus_stop;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a;
      a = {addr[7:4], 4'(k)};
      if (pm[k] && !(lock_lo && a < 8'h80)) mem_m[a] = pv[k];
    end
  endtask

  task automatic rd_seq(input logic [7:0] addr, input int n, input string req);
    logic [7:0] b;
    bus_start;
    tx_byte(dev(1'b0), 1'b1, req);
    tx_byte(addr, 1'b1, req);
    ptr_m = addr;
    bus_start;
    tx_byte(dev(1'b1), 1'b1, req);
    for (int i = 0; i < n; i++) begin
      rx_byte(i < n - 1, b);
      chk(req, b, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 256;
    end
    bus_stop;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run;
  end

  initial begin
    logic [7:0] b;
    wq(5); rst_n = 1'b1; wq(5);
    // R11: reset state
    chk("R11 oe after reset", int'(sda_oe), 0);
    bus_start; tx_byte(dev(1'b0), 1'b1, "R11 ack right after reset"); bus_stop;

    // R2: wrong strap and wrong type are ignored
    bus_start; tx_byte({4'b1010, 3'b100, 1'b0}, 1'b0, "R2 strap mismatch"); bus_stop;
    bus_start; tx_byte({4'b1011, STRAP, 1'b0}, 1'b0, "R2 type mismatch"); bus_stop;
    chk("R2 line released after mismatch", int'(sda_oe), 0);

    // R4 + R6: byte write, busy window
    wr_seq(8'h10, '{8'h11}, "R4 byte write");
    bus_start; tx_byte(dev(1'b0), 1'b0, "R6 nack while busy"); bus_stop;
    wq(WRC);
    bus_start; tx_byte(dev(1'b0), 1'b1, "R6 ack after write cycle"); bus_stop;
    rd_seq(8'h10, 1, "R4 R8 readback");

    // R5: page write with wrap and overwrite
    wr_seq(8'h2E, '{8'hA0,8'hA1,8'hA2,8'hA3,8'hA4,8'hA5,8'hA6,8'hA7,8'hA8,
                    8'hA9,8'hAA,8'hAB,8'hAC,8'hAD,8'hAE,8'hAF,8'hB0,8'hB1}, "R5 page write");
    wq(WRC + 50);
    rd_seq(8'h20, 16, "R5 page wrap readback");

    // R7: protection check
    wr_seq(8'h90, '{8'h55}, "R7 setup");
    wq(WRC + 50);
    lock_lo = 1'b1;
    wr_seq(8'h10, '{8'hEE}, "R7 denied write");
    wq(WRC + 50);
    wr_seq(8'h90, '{8'h77}, "R7 allowed write");
    wq(WRC + 50);
    lock_lo = 1'b0;
    rd_seq(8'h10, 1, "R7 denied keeps old");
    rd_seq(8'h90, 1, "R7 allowed stored");

    // R9: rollover and current-address read
    wr_seq(8'hFE, '{8'hC1, 8'hC2}, "R9 setup hi");
    wq(WRC + 50);
    wr_seq(8'h00, '{8'hC3, 8'hC4}, "R9 setup lo");
    wq(WRC + 50);
    rd_seq(8'hFE, 3, "R9 rollover");
    bus_start; tx_byte(dev(1'b1), 1'b1, "R9 current read");
    rx_byte(1'b0, b); chk("R9 current address byte", b, mem_m[ptr_m]);
    ptr_m = (ptr_m + 1) % 256;
    // R10: NACK ended the read, line released
    wq(Q); chk("R10 released after nack", int'(sda_oe), 0);
    bus_stop;

    // R12 + R1: write cut by repeated START is discarded
    wr_seq(8'h50, '{8'h21, 8'h22}, "R12 setup");
    wq(WRC + 50);
    bus_start; tx_byte(dev(1'b0), 1'b1, "R12 dev"); tx_byte(8'h50, 1'b1, "R12 addr");
    tx_byte(8'h99, 1'b1, "R12 data");
    bus_start; tx_byte(dev(1'b1), 1'b1, "R1 repeated start");
    rx_byte(1'b0, b); chk("R12 current byte after abort", b, 8'h22);
    bus_stop;
    bus_start; tx_byte(dev(1'b0), 1'b1, "R12 no write cycle"); bus_stop;
    rd_seq(8'h50, 1, "R12 old value kept");

    chk("R3 drive stable while SCL high", r3_viol, 0);
    finish_run;
  end
endmodule